// File: doc/BRIEF.md
# Wide ALU with Selectable Flag Groups

This block is the arithmetic and logic stage of a big-number coprocessor. It works on 256-bit operands and registers every result one clock after the operation is presented. It can add or subtract with an incoming carry or borrow. It can apply a bitwise operation to two operands, invert one operand, add or subtract a small immediate, or compare two operands. It can also pull a window out of a 512-bit concatenation of its two operands, pass one operand through, or choose between the two operands under the control of a flag.

Two independent flag groups are kept. A one-bit field on each operation names the group that the operation reads and the group it updates. This allows two carry chains to be interleaved without saving any state. For add, subtract and the three bitwise operations, the second operand can first be shifted by a whole number of bytes in either direction, with zeros filled in. Both flag groups can be read together at all times through a 32-bit status word.

Top module: `wide_alu`

## Requirements
- R1: An operation presented with `op_valid` high at a rising edge appears on `res_valid`, `res_we` and `result` after that same edge, and stays there until the next edge. When `op_valid` is low, no flag changes.
- R2: ADD and SUB produce `opnd_a` plus or minus the second operand, modulo 2^256. ADDI and SUBI use `imm`, zero-extended to 256 bits, as the second operand.
- R3: For ADD, SUB, AND, OR and XOR only, the second operand is `opnd_b` shifted by 8*`shift_bytes` bits, with zero fill. `shift_right`=1 shifts right and 0 shifts left. Every other operation ignores `shift_bytes`.
- R4: ADDC adds the C flag of the named group as a carry-in. SUBB subtracts it as a borrow-in. Arithmetic sets C on a carry-out. Subtraction sets C when the unsigned `opnd_a` is less than the second operand plus the borrow-in.
- R5: `fg_sel` names the flag group that is read and updated (0 or 1). The other group is never changed.
- R6: A flag group is 4 bits: C at bit 0, M (result bit 255) at bit 1, L (result bit 0) at bit 2 and Z (result is zero) at bit 3. AND, OR and XOR set M, L and Z from their result and clear C.
- R7: CMP and CMPB update the named group exactly as SUB and SUBB would, and drive `res_we` low.
- R8: SEL returns `opnd_a` when the flag picked by `flag_pick` (0 C, 1 M, 2 L, 3 Z) in the named group is 1, and `opnd_b` otherwise.
- R9: RSHI returns the low 256 bits of the 512-bit value {`opnd_a`,`opnd_b`} shifted right by `funnel_amt` (0 to 255).
- R10: NOT returns ~`opnd_a` and MOV returns `opnd_a`. NOT, MOV, SEL and RSHI leave both flag groups unchanged.
- R11: `flags_csr` equals {24'b0, group 1, group 0}. After reset, both groups and `res_valid` are zero.
- R12: `op_code` values are ADD 0, SUB 1, ADDC 2, SUBB 3, AND 4, OR 5, XOR 6, NOT 7, CMP 8, CMPB 9, ADDI 10, SUBI 11, RSHI 12, SEL 13, MOV 14. Code 15 is a no-op: `res_we` is low and the flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| fg_sel | input | 1 | Flag group read and updated |
| opnd_a | input | 256 | First operand |
| opnd_b | input | 256 | Second operand |
| shift_right | input | 1 | Pre-shift direction, 1 = right |
| shift_bytes | input | 5 | Pre-shift distance in bytes |
| funnel_amt | input | 8 | Bit distance for RSHI |
| imm | input | 10 | Immediate for ADDI and SUBI |
| flag_pick | input | 2 | Flag tested by SEL |
| res_valid | output | 1 | Result registered from the previous cycle |
| res_we | output | 1 | Result is meant to be written back |
| result | output | 256 | Registered result |
| flags_csr | output | 32 | Both flag groups packed together |

## Verification
The arithmetic operations are run on irregular full-width operands, and the same operands are then reused under byte shifts of 9, 15, 17, 23 and 31 in both directions. A shift on the wrong side, or fill from the wrong end, therefore shows up as a different word. An all-ones plus one addition and a small-minus-large subtraction give carry, borrow and zero flags that the following ADDC and SUBB must consume. These are issued alternately into the two groups, which separates a wrong group choice from a wrong flag value. Equal and unequal compares, selects on Z and L, funnel distances of 0, 117 and 255, an ADDC that carries a non-zero shift distance, and the no-op code cover the remaining corners.

// File: rtl/wide_alu_pkg.sv
// Shared types for the wide ALU: operation codes and the flag group layout.
package wide_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBB = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_CMP  = 4'd8,
        OP_CMPB = 4'd9,
        OP_ADDI = 4'd10,
        OP_SUBI = 4'd11,
        OP_RSHI = 4'd12,
        OP_SEL  = 4'd13,
        OP_MOV  = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    // Flag group: Z bit 3, L bit 2, M bit 1, C bit 0.
    typedef struct packed {
        logic z;
        logic l;
        logic m;
        logic c;
    } flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/wide_alu_preshift.sv
// Byte-granular shifter for the second operand.
// Assumes: the distance is in bytes; vacated bits are filled with zeros.
module wide_alu_preshift #(
    parameter int WIDTH = 256,
    parameter int SHB_W = $clog2(WIDTH / 8)
) (
    input  logic [WIDTH-1:0] din,
    input  logic             dir_right,
    input  logic [SHB_W-1:0] nbytes,
    output logic [WIDTH-1:0] dout
);

    localparam int AMT_W = SHB_W + 3;

    logic [AMT_W-1:0] amt_bits;

    // Turn the byte count into a bit count.
    assign amt_bits = {nbytes, 3'b000};

    // Logical shift in the chosen direction.
    always_comb begin
        if (dir_right) dout = din >> amt_bits;
        else           dout = din << amt_bits;
    end

endmodule

// File: rtl/wide_alu_arith.sv
// Shared adder for add and subtract, with an optional carry or borrow in.
// Assumes: cin_flag is already gated by the caller. c_flag reports the
// carry for add and the borrow for subtract.
module wide_alu_arith #(
    parameter int WIDTH = 256
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             sub,
    input  logic             cin_flag,
    output logic [WIDTH-1:0] sum,
    output logic             c_flag
);

    logic [WIDTH-1:0] y_in;
    logic             cin;
    logic             cout;

    // For subtract, invert the second operand and use the inverted borrow as carry-in.
    always_comb begin
        y_in = sub ? ~y : y;
        cin  = sub ? ~cin_flag : cin_flag;
    end

    // One full-width addition.
    assign {cout, sum} = {1'b0, x} + {1'b0, y_in} + {{WIDTH{1'b0}}, cin};

    // Subtraction borrows when there is no carry-out.
    assign c_flag = sub ? ~cout : cout;

endmodule

// File: rtl/wide_alu_flags.sv
// Storage for the two flag groups. Only the selected group is written.
// Assumes: wr_en is high for a single cycle for each flag-setting operation.
module wide_alu_flags
    import wide_alu_pkg::*;
#(
    parameter int NGRP = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   grp_sel,
    input  flags_t nxt,
    output flags_t grp0,
    output flags_t grp1
);

    flags_t grp_q [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // Load the new flags into this group when it is the one selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                                         grp_q[g] <= '0;
            else if (wr_en && (grp_sel == 1'(g)))               grp_q[g] <= nxt;
        end
    end

    assign grp0 = grp_q[0];
    assign grp1 = grp_q[1];

    // R5: writing group 0 leaves group 1 untouched, and the other way round.
    p_grp1_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !grp_sel) |=> $stable(grp1));
    p_grp0_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp_sel) |=> $stable(grp0));

endmodule

// File: rtl/wide_alu.sv
// 256-bit ALU with a byte pre-shift, funnel shift, flag select and two flag groups.
// Assumes: one operation per cycle. The result is registered and flags
// update on the same edge.
module wide_alu
    import wide_alu_pkg::*;
#(
    parameter int WIDTH = 256,
    parameter int IMM_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              fg_sel,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic              shift_right,
    input  logic [4:0]        shift_bytes,
    input  logic [7:0]        funnel_amt,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        flag_pick,
    output logic              res_valid,
    output logic              res_we,
    output logic [WIDTH-1:0]  result,
    output logic [31:0]       flags_csr
);

    localparam int SHB_W = $clog2(WIDTH / 8);

    alu_op_e          op;
    flags_t           grp0, grp1, cur, nxt_flags;
    logic [FLAG_W-1:0] cur_v;
    logic [WIDTH-1:0] b_sh, b_eff, imm_ext, arith_y, sum, nxt_res, flag_src, funnel_res;
    logic             pre_en, arith_sub, carry_use, c_arith, nxt_we, flag_wr, c_val;

    assign op      = alu_op_e'(op_code);
    assign cur     = fg_sel ? grp1 : grp0;
    assign cur_v   = cur;
    assign imm_ext = {{(WIDTH-IMM_W){1'b0}}, imm};

    wide_alu_preshift #(.WIDTH(WIDTH), .SHB_W(SHB_W)) u_preshift (
        .din       (opnd_b),
        .dir_right (shift_right),
        .nbytes    (shift_bytes[SHB_W-1:0]),
        .dout      (b_sh)
    );

    // The pre-shift applies only to add, sub and the bitwise operations.
    always_comb begin
        pre_en = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
                 (op == OP_OR)  || (op == OP_XOR);
        b_eff  = pre_en ? b_sh : opnd_b;
    end

    // Choose the adder's second operand, its mode, and whether a carry is consumed.
    always_comb begin
        arith_y   = b_eff;
        arith_sub = 1'b0;
        carry_use = 1'b0;
        case (op)
            OP_SUB, OP_CMP:   arith_sub = 1'b1;
            OP_ADDC:          carry_use = 1'b1;
            OP_SUBB, OP_CMPB: begin arith_sub = 1'b1; carry_use = 1'b1; end
            OP_ADDI:          arith_y = imm_ext;
            OP_SUBI:          begin arith_y = imm_ext; arith_sub = 1'b1; end
            default:          ;
        endcase
    end

    wide_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .x        (opnd_a),
        .y        (arith_y),
        .sub      (arith_sub),
        .cin_flag (carry_use & cur.c),
        .sum      (sum),
        .c_flag   (c_arith)
    );

    // Funnel shift: take the low half of the shifted concatenation.
    assign funnel_res = WIDTH'({opnd_a, opnd_b} >> funnel_amt);

    // Pick the result, the write-back strobe, and the source for the flags.
    always_comb begin
        nxt_res  = '0;
        nxt_we   = 1'b1;
        flag_wr  = 1'b0;
        flag_src = sum;
        c_val    = c_arith;
        case (op)
            OP_ADD, OP_SUB, OP_ADDC, OP_SUBB, OP_ADDI, OP_SUBI: begin
                nxt_res = sum;
                flag_wr = 1'b1;
            end
            OP_CMP, OP_CMPB: begin
                nxt_we  = 1'b0;
                flag_wr = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)     nxt_res = opnd_a & b_eff;
                else if (op == OP_OR) nxt_res = opnd_a | b_eff;
                else                  nxt_res = opnd_a ^ b_eff;
                flag_src = nxt_res;
                c_val    = 1'b0;
                flag_wr  = 1'b1;
            end
            OP_NOT:  nxt_res = ~opnd_a;
            OP_RSHI: nxt_res = funnel_res;
            OP_SEL:  nxt_res = cur_v[flag_pick] ? opnd_a : opnd_b;
            OP_MOV:  nxt_res = opnd_a;
            default: nxt_we  = 1'b0;
        endcase
    end

    // Form the new flag group from the flag source.
    always_comb begin
        nxt_flags.z = (flag_src == '0);
        nxt_flags.l = flag_src[0];
        nxt_flags.m = flag_src[WIDTH-1];
        nxt_flags.c = c_val;
    end

    wide_alu_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_valid & flag_wr),
        .grp_sel (fg_sel),
        .nxt     (nxt_flags),
        .grp0    (grp0),
        .grp1    (grp1)
    );

    // Register the result and its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_we    <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= op_valid;
            res_we    <= op_valid & nxt_we;
            if (op_valid) result <= nxt_res;
        end
    end

    // Pack both groups into the status word, group 1 above group 0.
    assign flags_csr = {{(32-2*FLAG_W){1'b0}}, grp1, grp0};

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    p_idle_keeps_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_csr));
    p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd8 || op_code == 4'd9)) |=> !res_we);
    p_logic_clears_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fg_sel && (op_code == 4'd4 || op_code == 4'd5 || op_code == 4'd6))
        |=> !flags_csr[0]);
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fg_sel && op_code == 4'd0) |=> (flags_csr[3] == (result == '0)));
    p_not_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd7) |=> $stable(flags_csr));

endmodule

// File: tb/wide_alu_test.sv
`timescale 1ns/1ps
module wide_alu_test;

    typedef struct packed {
        logic [255:0] res;
        logic         we;
        logic [31:0]  csr;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic         fg_sel = 1'b0;
    logic [255:0] opnd_a = '0, opnd_b = '0;
    logic         shift_right = 1'b0;
    logic [4:0]   shift_bytes = '0;
    logic [7:0]   funnel_amt = '0;
    logic [9:0]   imm = '0;
    logic [1:0]   flag_pick = '0;
    logic         res_valid, res_we;
    logic [255:0] result;
    logic [31:0]  flags_csr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t  expq[$];
    string tagq[$];
    logic [3:0] mfg [2];

    localparam logic [255:0] KA = 256'h5e3b91c70a44fd2813c67e9ba2d04f5188e73b0cc9156a720fd4e98327abb160;
    localparam logic [255:0] KB = 256'hc7a03d5e91f26b084e1da7c33590ee6b12f80b49d63a7c25a98e5f1764c20d3b;

    always #2.5 clk = ~clk;

    wide_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .fg_sel(fg_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_right(shift_right), .shift_bytes(shift_bytes),
        .funnel_amt(funnel_amt), .imm(imm), .flag_pick(flag_pick),
        .res_valid(res_valid), .res_we(res_we), .result(result), .flags_csr(flags_csr)
    );

    // Driver: compute the expected outcome from the requirements, queue it, drive the inputs.
    task automatic issue(input logic [3:0] op, input logic g, input logic [255:0] ta,
                         input logic [255:0] tb, input logic dir, input logic [4:0] nb,
                         input logic [7:0] fa, input logic [9:0] im, input logic [1:0] fp,
                         input string tag);
        logic [255:0] bs, r, fsrc;
        logic [256:0] w;
        logic [511:0] cat;
        logic [3:0]   cur;
        logic         c, upd, we;
        exp_t         e;
        cur = mfg[g];
        bs  = tb;
        if (op inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd6})
            bs = dir ? (tb >> ({3'b000, nb} * 8)) : (tb << ({3'b000, nb} * 8));
        r = '0; w = '0; c = 1'b0; upd = 1'b0; we = 1'b1;
        case (op)
            4'd0:  w = {1'b0, ta} + {1'b0, bs};
            4'd2:  w = {1'b0, ta} + {1'b0, bs} + 257'(cur[0]);
            4'd1, 4'd8:  w = {1'b0, ta} - {1'b0, bs};
            4'd3, 4'd9:  w = {1'b0, ta} - {1'b0, bs} - 257'(cur[0]);
            4'd10: w = {1'b0, ta} + 257'(im);
            4'd11: w = {1'b0, ta} - 257'(im);
            default: ;
        endcase
        fsrc = w[255:0];
        c    = w[256];
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd10, 4'd11: begin r = w[255:0]; upd = 1'b1; end
            4'd8, 4'd9: begin we = 1'b0; upd = 1'b1; end
            4'd4: begin r = ta & bs; fsrc = r; c = 1'b0; upd = 1'b1; end
            4'd5: begin r = ta | bs; fsrc = r; c = 1'b0; upd = 1'b1; end
            4'd6: begin r = ta ^ bs; fsrc = r; c = 1'b0; upd = 1'b1; end
            4'd7:  r = ~ta;
            4'd12: begin cat = {ta, tb} >> fa; r = cat[255:0]; end
            4'd13: r = cur[fp] ? ta : tb;
            4'd14: r = ta;
            default: we = 1'b0;
        endcase
        if (upd) mfg[g] = {(fsrc == '0), fsrc[0], fsrc[255], c};
        e.res = r; e.we = we; e.csr = {24'b0, mfg[1], mfg[0]};
        @(negedge clk);
        op_code = op; fg_sel = g; opnd_a = ta; opnd_b = tb; shift_right = dir;
        shift_bytes = nb; funnel_amt = fa; imm = im; flag_pick = fp; op_valid = 1'b1;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // Monitor: pop the oldest expectation each time a result is shown.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1 unexpected result: actual res_valid=1 expected 0");
            end else begin
                exp_t e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                checks++;
                if (res_we !== e.we || (e.we && result !== e.res)) begin
                    errors++;
                    $display("FAIL %s result: actual we=%0b %h expected we=%0b %h",
                             t, res_we, result, e.we, e.res);
                end
                checks++;
                if (flags_csr !== e.csr) begin
                    errors++;
                    $display("FAIL %s R11 flags: actual %h expected %h", t, flags_csr, e.csr);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mfg[0] = '0; mfg[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || flags_csr !== 32'h0) begin
            errors++;
            $display("FAIL R11 reset: actual valid=%0b csr=%h expected 0 0", res_valid, flags_csr);
        end
        issue(4'd0, 1'b0, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R1 R2 add");
        issue(4'd0, 1'b0, '1, 256'd1, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R6 wrap to zero");
        issue(4'd2, 1'b0, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R4 addc");
        issue(4'd1, 1'b1, 256'd3, 256'd5, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R4 R5 sub borrow");
        issue(4'd3, 1'b1, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R4 subb");
        issue(4'd4, 1'b0, KA, KB, 1'b0, 5'd9, 8'd0, 10'd0, 2'd0, "R3 R6 and shl");
        issue(4'd5, 1'b1, KA, KB, 1'b1, 5'd15, 8'd0, 10'd0, 2'd0, "R3 or shr");
        issue(4'd6, 1'b0, KA, KB, 1'b0, 5'd17, 8'd0, 10'd0, 2'd0, "R3 xor shl");
        issue(4'd1, 1'b0, KA, KB, 1'b1, 5'd23, 8'd0, 10'd0, 2'd0, "R3 sub shr");
        issue(4'd2, 1'b1, KA, KB, 1'b0, 5'd4, 8'd0, 10'd0, 2'd0, "R3 addc shift ignored");
        issue(4'd7, 1'b0, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R10 not");
        issue(4'd8, 1'b0, KA, KA, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R7 cmp equal");
        issue(4'd9, 1'b1, KB, KA, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R7 cmpb");
        issue(4'd13, 1'b0, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd3, "R8 sel z");
        issue(4'd13, 1'b1, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd2, "R8 sel l");
        issue(4'd10, 1'b0, KA, KB, 1'b0, 5'd0, 8'd0, 10'h207, 2'd0, "R2 addi");
        issue(4'd11, 1'b1, 256'd5, KB, 1'b0, 5'd0, 8'd0, 10'h3ff, 2'd0, "R2 subi borrow");
        issue(4'd12, 1'b0, KA, KB, 1'b0, 5'd0, 8'd117, 10'd0, 2'd0, "R9 funnel 117");
        issue(4'd12, 1'b0, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R9 funnel 0");
        issue(4'd12, 1'b1, KA, KB, 1'b0, 5'd0, 8'd255, 10'd0, 2'd0, "R9 funnel 255");
        issue(4'd14, 1'b0, KB, KA, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R10 mov");
        issue(4'd15, 1'b1, KA, KB, 1'b0, 5'd0, 8'd0, 10'd0, 2'd0, "R12 nop");
        issue(4'd0, 1'b1, KA, KB, 1'b1, 5'd31, 8'd0, 10'd0, 2'd0, "R3 add shr 31");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R1 pending results: actual %0d expected 0", expq.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule